// File: doc/BRIEF.md
# SPI NOR Flash Controller with Direct-Mapped Window

This block connects a simple 32-bit request/acknowledge bus to one SPI NOR flash device. It uses one chip select and single-bit data. The top address bit splits the bus space into two regions. One region holds three control registers. The other is a data window onto the flash.

Software first picks a mode in the control register.

- **Raw byte mode:** every window access is shifted out unchanged as SPI bytes. Software frames the transaction itself with a chip-select release bit.
- **Direct modes:** each window access becomes a complete flash transaction. The controller sends a stored opcode, then the access address, then an optional dummy byte for fast reads, then the data. It drives chip select on its own.

The SPI clock is derived from the system clock by a fixed divider and uses mode 0. The bus acknowledge waits until the last SPI bit has been transferred.

Top module: `spi_flash_ctl`

## Requirements
- R1: After reset, `spi_cs_n` is 1 and `spi_sclk` is 0. The registers read as follows:
  - setup register (offset 0x0): 0
  - address-width register (offset 0x4): 0
  - control register (offset 0x8): 0x00030004
- R2: The control register fields are:
  - bits [1:0] select the mode: 0 = read, 1 = fast read, 2 = program, 3 = raw byte mode.
  - bits [23:16] hold the opcode that direct modes send first.
  - bit 2 is the chip-select release bit.
- R3: In raw byte mode, clearing the release bit drives `spi_cs_n` low, and setting it again drives `spi_cs_n` high. In direct modes, `spi_cs_n` is low only for the duration of each window transaction.
- R4: In raw byte mode, a byte access to the window transfers one SPI byte through bus lane [7:0]. A word access transfers four bytes, starting with lane [7:0] and ending with lane [31:24]. Each byte is sent most significant bit first in SPI mode 0: data changes only while `spi_sclk` is low, the clock idles low, and one bit takes 2*DIV clock cycles.
- R5: A direct read sends the opcode, then 3 address bytes (most significant first), then the data bytes. The first received byte is returned in lane [7:0].
- R6: When bit 0 of the address-width register is 1, direct transactions send 4 address bytes instead of 3.
- R7: In fast-read mode, one dummy byte of 0x00 is sent between the address and the data.
- R8: In program mode, a window write sends the opcode, the address and then the write data in lane order. This happens only if bit 16 of the setup register is 1.
- R9: While setup bit 16 is 0, every window write is acknowledged but produces no SPI clock edge and no chip-select pulse.
- R10: A change to the mode field takes effect only once `spi_cs_n` is high. While a raw-byte frame is held open, window accesses stay raw.
- R11: `bus_ack` is high for exactly one cycle per accepted request.
- R12: A window access in raw byte mode while chip select is released is acknowledged, returns 0 and produces no SPI clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Request, held until acknowledged |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = 32-bit access, 0 = byte access on lane [7:0] |
| bus_addr | input | ADDR_W | Top bit selects the window; below that, the register offset or flash address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_ack` is high |
| bus_ack | output | 1 | One-cycle completion pulse |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sclk | output | 1 | SPI clock (mode 0) |
| spi_mosi | output | 1 | Data to flash |
| spi_miso | input | 1 | Data from flash |

## Verification
The delicate overlap is a control-register write that changes the mode field while a raw-byte frame is still open. In that cycle the controller both stores the new mode and holds the old one as the active mode. The bench opens a raw frame, writes a direct mode with the release bit still clear, and then makes a window read. The check passes only if chip select stays low and exactly one raw byte (no opcode or address) appears on the wire. Setting the release bit then produces a full direct transaction on the next read.

// File: rtl/spi_flash_ctl.sv
module spi_flash_ctl #(
  parameter int ADDR_W = 32,
  parameter int DIV    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_write,
  input  logic              bus_word,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_ack,
  output logic              spi_cs_n,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int CW = $clog2(DIV + 1);

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_LOW, S_HIGH, S_DONE} st_t;

  st_t         st;
  logic [31:0] conf_q, ctrl_q, tx_buf, rd_buf;
  logic        wide_q, direct, is_data;
  logic [1:0]  act_mode, lane;
  logic [47:0] hdr_sr;
  logic [2:0]  hdr_left, dat_left, bitn;
  logic [7:0]  tx_sh, rx_sh;
  logic [CW-1:0] div;

  logic        win, user_cs, raw;
  logic [31:0] woff, reg_rd;
  logic [2:0]  hdr_len;
  logic [47:0] hdr_load;

  assign win      = bus_addr[ADDR_W-1];
  assign woff     = {{(33-ADDR_W){1'b0}}, bus_addr[ADDR_W-2:0]};
  assign raw      = (act_mode == 2'd3);
  assign user_cs  = raw && !ctrl_q[2];
  assign hdr_len  = 3'd1 + (wide_q ? 3'd4 : 3'd3) + {2'b00, act_mode == 2'd1};
  assign hdr_load = wide_q ? {ctrl_q[23:16], woff, 8'h00}
                           : {ctrl_q[23:16], woff[23:0], 16'h0000};
  assign spi_mosi = tx_sh[7];

  always_comb begin
    case (bus_addr[3:2])
      2'd0:    reg_rd = conf_q;
      2'd1:    reg_rd = {31'b0, wide_q};
      2'd2:    reg_rd = ctrl_q;
      default: reg_rd = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      conf_q <= '0; wide_q <= 1'b0; ctrl_q <= 32'h0003_0004;
      act_mode <= 2'd0; direct <= 1'b0; is_data <= 1'b0;
      hdr_sr <= '0; hdr_left <= '0; dat_left <= '0; bitn <= '0;
      tx_buf <= '0; rd_buf <= '0; lane <= '0;
      tx_sh <= '0; rx_sh <= '0; div <= '0;
      spi_cs_n <= 1'b1; spi_sclk <= 1'b0;
      bus_ack <= 1'b0; bus_rdata <= '0;
    end else begin
      bus_ack <= 1'b0;
      case (st)
        S_IDLE: begin
          if (spi_cs_n) act_mode <= ctrl_q[1:0];
          spi_cs_n <= !user_cs;
          if (bus_req && !bus_ack) begin
            if (!win) begin
              bus_ack   <= 1'b1;
              bus_rdata <= reg_rd;
              if (bus_write) begin
                case (bus_addr[3:2])
                  2'd0:    conf_q <= bus_wdata;
                  2'd1:    wide_q <= bus_wdata[0];
                  2'd2:    ctrl_q <= bus_wdata;
                  default: ;
                endcase
              end
            end else if ((bus_write && !conf_q[16]) || (raw && spi_cs_n)) begin
              bus_ack   <= 1'b1;
              bus_rdata <= '0;
            end else begin
              direct   <= !raw;
              if (!raw) spi_cs_n <= 1'b0;
              hdr_sr   <= hdr_load;
              hdr_left <= raw ? 3'd0 : hdr_len;
              dat_left <= bus_word ? 3'd4 : 3'd1;
              tx_buf   <= bus_write ? bus_wdata : 32'h0;
              rd_buf   <= '0;
              lane     <= '0;
              st       <= S_LOAD;
            end
          end
        end
        S_LOAD: begin
          if (hdr_left != 3'd0) begin
            tx_sh    <= hdr_sr[47:40];
            hdr_sr   <= {hdr_sr[39:0], 8'h00};
            hdr_left <= hdr_left - 3'd1;
            is_data  <= 1'b0;
          end else begin
            tx_sh    <= tx_buf[7:0];
            tx_buf   <= {8'h00, tx_buf[31:8]};
            dat_left <= dat_left - 3'd1;
            is_data  <= 1'b1;
          end
          bitn <= '0;
          div  <= '0;
          st   <= S_LOW;
        end
        S_LOW: begin
          if (div == CW'(DIV - 1)) begin
            div      <= '0;
            spi_sclk <= 1'b1;
            rx_sh    <= {rx_sh[6:0], spi_miso};
            st       <= S_HIGH;
          end else div <= div + 1'b1;
        end
        S_HIGH: begin
          if (div == CW'(DIV - 1)) begin
            div      <= '0;
            spi_sclk <= 1'b0;
            if (bitn == 3'd7) begin
              if (is_data) begin
                rd_buf[{lane, 3'b000} +: 8] <= rx_sh;
                lane <= lane + 2'd1;
              end
              st <= (hdr_left == 3'd0 && dat_left == 3'd0) ? S_DONE : S_LOAD;
            end else begin
              bitn  <= bitn + 3'd1;
              tx_sh <= {tx_sh[6:0], 1'b0};
              st    <= S_LOW;
            end
          end else div <= div + 1'b1;
        end
        S_DONE: begin
          if (direct) spi_cs_n <= 1'b1;
          bus_ack   <= 1'b1;
          bus_rdata <= rd_buf;
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_flash_ctl_chk.sv
module spi_flash_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_ack,
  input logic       spi_cs_n,
  input logic       spi_sclk,
  input logic       spi_mosi,
  input logic [1:0] act_mode
);
  assert_ack_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |=> !bus_ack);

  assert_clock_only_selected_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sclk) |-> !spi_cs_n);

  assert_idle_low_at_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> !spi_sclk);

  assert_mosi_steady_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

  assert_mode_held_in_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_cs_n && $past(!spi_cs_n)) |-> $stable(act_mode));
endmodule

bind spi_flash_ctl spi_flash_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_ack(bus_ack), .spi_cs_n(spi_cs_n),
  .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .act_mode(act_mode)
);

// File: tb/tb_spi_flash_ctl.sv
`timescale 1ns/1ps
module tb_spi_flash_ctl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_req = 0, bus_write = 0, bus_word = 0;
  logic [31:0] bus_addr = '0, bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_ack, spi_cs_n, spi_sclk, spi_mosi;
  logic spi_miso = 1'b0;

  always #10 clk = ~clk;

  spi_flash_ctl dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_write(bus_write),
    .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack), .spi_cs_n(spi_cs_n),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int total = 0, bad = 0;
  int rises = 0, frames = 0, bidx = 0, byidx = 0;
  logic [7:0] cap = '0;
  logic [7:0] expq[$];
  string cur = "R0";

  function automatic logic [7:0] pat(input int i);
    return 8'hC0 + 8'(i);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // flash-side model and scoreboard monitor
  always @(negedge spi_cs_n) begin
    frames++; bidx = 0; byidx = 0;
    spi_miso = pat(0)[7];
  end
  always @(posedge spi_sclk) begin
    rises++;
    cap = {cap[6:0], spi_mosi};
    bidx++;
    if (bidx == 8) begin
      bidx = 0;
      byidx++;
      total++;
      if (expq.size() == 0) begin
        bad++;
        $display("FAIL %s actual=%h expected=<none>", cur, cap);
      end else begin
        logic [7:0] e;
        e = expq.pop_front();
        if (e !== cap) begin
          bad++;
          $display("FAIL %s actual=%h expected=%h", cur, cap, e);
        end
      end
    end
  end
  always @(negedge spi_sclk) spi_miso = pat(byidx)[3'(7 - bidx)];

  task automatic push(input logic [7:0] b);
    expq.push_back(b);
  endtask

  task automatic bus(input bit w, input bit win, input bit word,
                     input logic [31:0] a, input logic [31:0] d,
                     output logic [31:0] r);
    @(negedge clk);
    bus_req = 1; bus_write = w; bus_word = word;
    bus_addr = win ? {1'b1, a[30:0]} : a;
    bus_wdata = d;
    forever begin
      @(negedge clk);
      if (bus_ack) break;
    end
    r = bus_rdata;
    bus_req = 0; bus_write = 0;
    @(negedge clk);
    check("R11", {31'b0, bus_ack}, 32'h0);
  endtask

  task automatic regw(input logic [3:0] off, input logic [31:0] d);
    logic [31:0] r;
    bus(1, 0, 1, {28'h0, off}, d, r);
  endtask

  task automatic drained(input string req);
    check(req, expq.size(), 0);
  endtask

  task automatic finish_up;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_up();
  end

  initial begin
    logic [31:0] r;
    int rs, fr;
    repeat (3) @(negedge clk);
    check("R1", {31'b0, spi_cs_n}, 32'h1);
    check("R1", {31'b0, spi_sclk}, 32'h0);
    rst_n = 1;
    bus(0, 0, 1, 32'h0, 0, r); check("R1", r, 32'h0);
    bus(0, 0, 1, 32'h4, 0, r); check("R1", r, 32'h0);
    bus(0, 0, 1, 32'h8, 0, r); check("R1", r, 32'h0003_0004);

    // raw byte mode framing and lane order
    cur = "R4";
    regw(4'h0, 32'h0001_0000);
    regw(4'h8, 32'h0003_0007);
    regw(4'h8, 32'h0003_0003);
    @(negedge clk); check("R3", {31'b0, spi_cs_n}, 32'h0);
    push(8'h9F); bus(1, 1, 0, 0, 32'h9F, r);
    push(8'h00); bus(0, 1, 0, 0, 0, r); check("R4", r, {24'h0, pat(1)});
    push(8'h00); bus(0, 1, 0, 0, 0, r); check("R4", r, {24'h0, pat(2)});
    push(8'h00); bus(0, 1, 0, 0, 0, r); check("R4", r, {24'h0, pat(3)});
    push(8'h11); push(8'h22); push(8'h33); push(8'h44);
    bus(1, 1, 1, 0, 32'h4433_2211, r);
    push(8'h00); push(8'h00); push(8'h00); push(8'h00);
    bus(0, 1, 1, 0, 0, r);
    check("R4", r, {pat(11), pat(10), pat(9), pat(8)});
    drained("R4");
    check("R3", frames, 1);
    regw(4'h8, 32'h0003_0007);
    @(negedge clk); check("R3", {31'b0, spi_cs_n}, 32'h1);

    // mode change while frame is open
    cur = "R10";
    regw(4'h8, 32'h0003_0003);
    regw(4'h8, 32'h0003_0000);
    @(negedge clk); check("R10", {31'b0, spi_cs_n}, 32'h0);
    push(8'h00); bus(0, 1, 0, 32'h0012_3456, 0, r);
    check("R10", r, {24'h0, pat(0)});
    drained("R10");
    regw(4'h8, 32'h0003_0004);
    @(negedge clk); check("R10", {31'b0, spi_cs_n}, 32'h1);

    // direct read, 3-byte address
    cur = "R5";
    fr = frames;
    push(8'h03); push(8'h12); push(8'h34); push(8'h56);
    repeat (4) push(8'h00);
    bus(0, 1, 1, 32'h0012_3456, 0, r);
    check("R5", r, {pat(7), pat(6), pat(5), pat(4)});
    drained("R5");
    check("R5", frames - fr, 1);
    check("R3", {31'b0, spi_cs_n}, 32'h1);

    // 4-byte address
    cur = "R6";
    regw(4'h4, 32'h1);
    push(8'h03); push(8'h01); push(8'hAB); push(8'hCD); push(8'hEF); push(8'h00);
    bus(0, 1, 0, 32'h01AB_CDEF, 0, r);
    check("R6", r, {24'h0, pat(5)});
    drained("R6");

    // fast read with dummy byte
    cur = "R7";
    regw(4'h4, 32'h0);
    regw(4'h8, 32'h000B_0005);
    push(8'h0B); push(8'h00); push(8'h00); push(8'h10); push(8'h00); push(8'h00);
    bus(0, 1, 0, 32'h0000_0010, 0, r);
    check("R7", r, {24'h0, pat(5)});
    drained("R7");

    // program
    cur = "R8";
    regw(4'h8, 32'h0002_0006);
    push(8'h02); push(8'h00); push(8'h01); push(8'h00);
    push(8'hAA); push(8'hBB); push(8'hCC); push(8'hDD);
    bus(1, 1, 1, 32'h0000_0100, 32'hDDCC_BBAA, r);
    drained("R8");
    check("R2", {31'b0, spi_cs_n}, 32'h1);

    // writes blocked without enable
    cur = "R9";
    regw(4'h0, 32'h0);
    rs = rises; fr = frames;
    bus(1, 1, 1, 32'h0000_0200, 32'h1234_5678, r);
    check("R9", rises - rs, 0);
    check("R9", frames - fr, 0);

    // raw access with chip select released
    cur = "R12";
    regw(4'h8, 32'h0003_0007);
    rs = rises;
    bus(0, 1, 1, 32'h0, 0, r);
    check("R12", r, 32'h0);
    check("R12", rises - rs, 0);
    check("R12", {31'b0, spi_cs_n}, 32'h1);

    finish_up();
  end
endmodule